// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block watches a keypad of six row lines and five column lines. The column lines are pulled low outside the block. While the keypad is idle, the row lines sit at a standby level and no scanning takes place. When any column goes high, the block opens an 800-cycle acceptance window. In that window it scans every row twice, one row at a time, and compares the two results. If the two scans agree, it publishes a 30-bit key map and a sleep-acknowledge flag, then pulls its active-low request line low. If the two scans disagree, it opens another window.

The request and the key map form a hold-until-done handshake rather than a flowing stream. While the request is low, the key map and the flag stay frozen. The host may raise chip-select during its transfer, which forces the request line high. A one-cycle read-complete strobe then releases the data and starts a fresh window. That fresh window ends in another request while keys are still held. Once every key has been released, it returns to idle. There is no back-pressure: a second pattern is never offered until the host strobes read-complete.

A two-bit sleep code picks the standby row levels. In sleep, only the rows that are driven high can wake the block. A two-bit segment code takes the first one or two rows away from the keypad.

Top module: `key_matrix_scanner`

## Requirements
- R1: In idle, a window starts on the first clock edge at which any column input is high. With all columns low, no window starts and the row outputs stay at the standby pattern.
- R2: During a window, the first scan occupies window cycles 0 to 374 and the second scan cycles 375 to 749. Within each scan, rows are driven high one at a time in the order row 1 to row 6, each for 62 cycles. The columns are sampled on the last cycle of each row's slot. At all other times inside the window, every row output is low.
- R3: If the two scans agree, the request output falls on the 800th clock edge after the window's start edge, and the key map is loaded on that same edge.
- R4: If the two scans disagree, a new window starts at once. The request then falls 1600 edges after the first start edge.
- R5: The key at row r, column c (both counted from 1) appears at key map bit index 5(r-1)+c-1, so keys 1 to 30 map to bits 0 to 29.
- R6: Standby row levels follow the sleep code, where row_o bit 0 is row 1. Code 00 drives all rows high. Code 01 drives only row 6 high. Code 10 drives rows 5 and 6 high. Code 11 drives rows 2 to 6 high. A nonzero code is sleep.
- R7: The segment code takes rows away from the keypad. Code 00 takes none, code 01 takes row 1, and codes 10 and 11 take rows 1 and 2. A row taken this way is never driven high, and its key bits read 0. With code 1x, key bits 0 to 9 are always 0.
- R8: The sleep-acknowledge output holds 1 if the sleep code was nonzero on the window's start edge, and 0 otherwise. It is loaded together with the key map.
- R9: While a request is pending, chip-select high forces the request output high. The key map and the flag do not change until read-complete.
- R10: A read-complete strobe while a request is pending starts a new window on the next edge. If both of that window's scans see no key, the block returns to idle with the request high and the key map cleared.
- R11: While rst_n is low, the key map and the flag are 0, the request is high, scanning stops and the rows show the standby pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_i | input | 5 | Column sense lines, high when a driven row meets a pressed key |
| sleep_sel_i | input | 2 | Sleep code selecting standby row levels |
| seg_sel_i | input | 2 | Code taking rows 1 and 2 away from the keypad |
| cs_i | input | 1 | Host chip-select; high during a transfer |
| rd_done_i | input | 1 | One-cycle strobe: host has read the key map |
| row_o | output | 6 | Row drive lines, bit 0 is row 1 |
| keys_o | output | 30 | Accepted key map, bit 5(r-1)+c-1 |
| sa_o | output | 1 | Press happened in sleep |
| req_n_o | output | 1 | Active-low read request |

## Verification
A bad window counter or slot counter shows up in two places. It would appear at row_o within one slot (62 cycles) as a wrong row or a row out of order. It would also appear as a request edge that lands off the exact 800 or 1600 count. A wrong buffer select or a broken compare shows up as a request after a changing press arriving at 800 instead of 1600, or as a key map bit in the wrong place. A state machine stuck in the pending state shows up as the request staying low after read-complete, or as the key map not clearing one window later.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  localparam int unsigned KS_ROWS     = 6;
  localparam int unsigned KS_COLS     = 5;
  localparam int unsigned KS_SCAN_CYC = 375;
  localparam int unsigned KS_WIN_CYC  = 800;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } kscan_state_e;
endpackage

// File: rtl/kscan_timer.sv
module kscan_timer #(
  parameter int unsigned ROWS     = 6,
  parameter int unsigned SCAN_CYC = 375,
  parameter int unsigned WIN_CYC  = 800,
  localparam int unsigned SLOT    = SCAN_CYC / ROWS,
  localparam int unsigned CW      = $clog2(WIN_CYC),
  localparam int unsigned SW      = $clog2(SLOT),
  localparam int unsigned RW      = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          run_i,
  output logic          win_end_o,
  output logic          sample_o,
  output logic          second_o,
  output logic          active_o,
  output logic [RW-1:0] row_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [RW-1:0] row_q, row_d;

  assign win_end_o = run_i && (cnt_q == CW'(WIN_CYC - 1));
  assign active_o  = run_i && (row_q < RW'(ROWS));
  assign sample_o  = active_o && (slot_q == SW'(SLOT - 1));
  assign second_o  = (cnt_q >= CW'(SCAN_CYC));
  assign row_o     = row_q;

  always_comb begin
    cnt_d  = cnt_q;
    slot_d = slot_q;
    row_d  = row_q;
    if (start_i || win_end_o) begin
      cnt_d  = '0;
      slot_d = '0;
      row_d  = '0;
    end else if (run_i) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(SCAN_CYC - 1)) begin
        slot_d = '0;
        row_d  = '0;
      end else if (row_q < RW'(ROWS)) begin
        if (slot_q == SW'(SLOT - 1)) begin
          slot_d = '0;
          row_d  = row_q + 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
      row_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      row_q  <= row_d;
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(WIN_CYC));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && !win_end_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/kscan_capture.sv
module kscan_capture #(
  parameter int unsigned ROWS = 6,
  parameter int unsigned COLS = 5,
  localparam int unsigned KEYS = ROWS * COLS,
  localparam int unsigned RW   = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_i,
  input  logic            second_i,
  input  logic [RW-1:0]   row_i,
  input  logic [COLS-1:0] col_i,
  output logic [KEYS-1:0] first_o,
  output logic            agree_o
);
  logic [KEYS-1:0] pass_a_q, pass_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_a_q <= '0;
      pass_b_q <= '0;
    end else if (sample_i) begin
      if (second_i) pass_b_q[row_i*COLS +: COLS] <= col_i;
      else          pass_a_q[row_i*COLS +: COLS] <= col_i;
    end
  end

  assign first_o = pass_a_q;
  assign agree_o = (pass_a_q == pass_b_q);

  // R2
  sample_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |-> (row_i < RW'(ROWS)));
endmodule

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
#(
  parameter int unsigned KEYS = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            col_any_i,
  input  logic            sleep_on_i,
  input  logic            rd_done_i,
  input  logic            cs_i,
  input  logic            win_end_i,
  input  logic            agree_i,
  input  logic [KEYS-1:0] data_i,
  output logic            start_o,
  output logic            run_o,
  output logic [KEYS-1:0] keys_o,
  output logic            sa_o,
  output logic            req_n_o
);
  kscan_state_e    state_q, state_d;
  logic [KEYS-1:0] keys_q;
  logic            sa_q, sa_pend_q;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (col_any_i) begin
        state_d = ST_SCAN;
        start_o = 1'b1;
      end
      ST_SCAN: if (win_end_i && agree_i) begin
        state_d = (|data_i) ? ST_HOLD : ST_IDLE;
      end
      ST_HOLD: if (rd_done_i) begin
        state_d = ST_SCAN;
        start_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      keys_q    <= '0;
      sa_q      <= 1'b0;
      sa_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_o) sa_pend_q <= sleep_on_i;
      if (state_q == ST_SCAN && win_end_i && agree_i) begin
        keys_q <= data_i;
        sa_q   <= sa_pend_q;
      end
    end
  end

  assign run_o   = (state_q == ST_SCAN);
  assign keys_o  = keys_q;
  assign sa_o    = sa_q;
  assign req_n_o = (state_q != ST_HOLD) || cs_i;

  // R9
  keys_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q == ST_HOLD)) |-> ($stable(keys_q) && $stable(sa_q)));

  // R3
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_HOLD) |-> $past(win_end_i && agree_i));

  // R10
  rescan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && rd_done_i) |=> (state_q == ST_SCAN));
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
  import kscan_pkg::*;
#(
  parameter int unsigned ROWS     = KS_ROWS,
  parameter int unsigned COLS     = KS_COLS,
  parameter int unsigned SCAN_CYC = KS_SCAN_CYC,
  parameter int unsigned WIN_CYC  = KS_WIN_CYC,
  localparam int unsigned KEYS    = ROWS * COLS,
  localparam int unsigned RW      = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS-1:0] col_i,
  input  logic [1:0]      sleep_sel_i,
  input  logic [1:0]      seg_sel_i,
  input  logic            cs_i,
  input  logic            rd_done_i,
  output logic [ROWS-1:0] row_o,
  output logic [KEYS-1:0] keys_o,
  output logic            sa_o,
  output logic            req_n_o
);
  logic            start, run, win_end, sample, second, active, agree;
  logic [RW-1:0]   row_idx;
  logic [KEYS-1:0] first_pass, key_mask;
  logic [ROWS-1:0] seg_row, idle_row, scan_row;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == 0) begin : g_first
      assign seg_row[r] = |seg_sel_i;
    end else if (r == 1) begin : g_second
      assign seg_row[r] = seg_sel_i[1];
    end else begin : g_rest
      assign seg_row[r] = 1'b0;
    end
    always_comb begin
      unique case (sleep_sel_i)
        2'b00:   idle_row[r] = 1'b1;
        2'b01:   idle_row[r] = (r == ROWS - 1);
        2'b10:   idle_row[r] = (r >= ROWS - 2);
        default: idle_row[r] = (r >= 1);
      endcase
    end
    assign key_mask[r*COLS +: COLS] = {COLS{~seg_row[r]}};
  end

  assign scan_row = active ? (ROWS'(1) << row_idx) : '0;
  assign row_o    = (run ? scan_row : idle_row) & ~seg_row;

  kscan_timer #(
    .ROWS(ROWS), .SCAN_CYC(SCAN_CYC), .WIN_CYC(WIN_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(run),
    .win_end_o(win_end), .sample_o(sample), .second_o(second),
    .active_o(active), .row_o(row_idx)
  );

  kscan_capture #(
    .ROWS(ROWS), .COLS(COLS)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .second_i(second),
    .row_i(row_idx), .col_i(col_i), .first_o(first_pass), .agree_o(agree)
  );

  kscan_ctrl #(
    .KEYS(KEYS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .col_any_i(|col_i),
    .sleep_on_i(|sleep_sel_i), .rd_done_i(rd_done_i), .cs_i(cs_i),
    .win_end_i(win_end), .agree_i(agree), .data_i(first_pass & key_mask),
    .start_o(start), .run_o(run), .keys_o(keys_o), .sa_o(sa_o),
    .req_n_o(req_n_o)
  );

  // R2
  rows_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> $onehot0(row_o));

  // R7
  seg_rows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_o & seg_row) == '0);
endmodule

// File: tb/key_matrix_scanner_test.sv
module key_matrix_scanner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  col;
  logic [1:0]  sleep_sel = 2'b00;
  logic [1:0]  seg_sel = 2'b00;
  logic        cs = 1'b0;
  logic        rd_done = 1'b0;
  logic [5:0]  row;
  logic [29:0] keys;
  logic        sa, req_n;
  logic [29:0] press = '0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  key_matrix_scanner uut (
    .clk(clk), .rst_n(rst_n), .col_i(col), .sleep_sel_i(sleep_sel),
    .seg_sel_i(seg_sel), .cs_i(cs), .rd_done_i(rd_done),
    .row_o(row), .keys_o(keys), .sa_o(sa), .req_n_o(req_n)
  );

  always_comb begin
    col = '0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 5; c++)
        if (press[5*r + c] && row[r]) col[c] = 1'b1;
  end

  typedef struct packed {
    logic [29:0] keys_dn;
    logic [1:0]  slp;
    logic [1:0]  seg;
    logic [29:0] want;
    logic        want_sa;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{30'h1 << 0,               2'b00, 2'b00, 30'h1 << 0,  1'b0},
    '{30'h1 << 29,              2'b00, 2'b00, 30'h1 << 29, 1'b0},
    '{(30'h1 << 11) | (30'h1 << 18), 2'b00, 2'b00, (30'h1 << 11) | (30'h1 << 18), 1'b0},
    '{30'h1 << 27,              2'b01, 2'b00, 30'h1 << 27, 1'b1},
    '{30'h1 << 8,               2'b11, 2'b00, 30'h1 << 8,  1'b1},
    '{30'h1 << 5,               2'b00, 2'b01, 30'h1 << 5,  1'b0},
    '{(30'h1 << 0) | (30'h1 << 14), 2'b00, 2'b10, 30'h1 << 14, 1'b0},
    '{30'h1 << 21,              2'b10, 2'b00, 30'h1 << 21, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_rows(input int m);
    int p;
    p = (m < 375) ? m : ((m < 750) ? m - 375 : -1);
    if (p < 0 || p >= 372) return 6'b0;
    return 6'b1 << (p / 62);
  endfunction

  // Waits for req_n low; returns posedge count since the press (0 = none).
  task automatic wait_req(input int limit, input int swap_at, input logic [29:0] alt,
                          input bit row_chk, output int lat);
    lat = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (i == swap_at) press = alt;
      if (row_chk && (i == 1 || i == 62 || i == 63 || i == 372 || i == 373 ||
                      i == 376 || i == 761))
        chk(row == exp_rows(i - 1), "R2 row order", 64'(row), 64'(exp_rows(i - 1)));
      if (!req_n) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic release_and_read();
    @(negedge clk);
    press = '0;
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    repeat (805) @(posedge clk);
    #1;
    chk(req_n == 1'b1, "R10 request idle", 64'(req_n), 64'd1);
    chk(keys == 30'h0, "R10 keys cleared", 64'(keys), 64'd0);
  endtask

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    #1;
    chk(req_n == 1'b1, "R11 req in reset", 64'(req_n), 64'd1);
    chk(keys == 30'h0 && sa == 1'b0, "R11 keys in reset", 64'({sa, keys}), 64'd0);
    chk(row == 6'h3f, "R11 rows in reset", 64'(row), 64'h3f);
    @(negedge clk);
    rst_n = 1'b1;

    // R6 standby rows per sleep code
    sleep_sel = 2'b01; #1;
    chk(row == 6'b100000, "R6 code 01", 64'(row), 64'h20);
    sleep_sel = 2'b10; #1;
    chk(row == 6'b110000, "R6 code 10", 64'(row), 64'h30);
    sleep_sel = 2'b11; #1;
    chk(row == 6'b111110, "R6 code 11", 64'(row), 64'h3e);
    sleep_sel = 2'b00; seg_sel = 2'b10; #1;
    chk(row == 6'b111100, "R7 seg rows idle", 64'(row), 64'h3c);
    seg_sel = 2'b01; #1;
    chk(row == 6'b111110, "R7 seg row1 idle", 64'(row), 64'h3e);
    seg_sel = 2'b00;

    // R1 no press, no window
    repeat (100) @(posedge clk);
    #1;
    chk(req_n == 1'b1 && row == 6'h3f, "R1 quiet idle", 64'({req_n, row}), 64'h7f);

    // R1 sleep code 01: a row-3 key cannot wake
    @(negedge clk);
    sleep_sel = 2'b01;
    press = 30'h1 << 10;
    wait_req(900, 0, '0, 1'b0, lat);
    chk(lat == 0 && row == 6'b100000, "R1 no wake in sleep", 64'(lat), 64'd0);
    @(negedge clk);
    press = '0; sleep_sel = 2'b00;

    // R7 key on a segment row alone never starts a window
    @(negedge clk);
    seg_sel = 2'b10;
    press = 30'h1 << 0;
    wait_req(900, 0, '0, 1'b0, lat);
    chk(lat == 0, "R7 segment row press", 64'(lat), 64'd0);
    @(negedge clk);
    press = '0; seg_sel = 2'b00;

    // R3 table walk: exact latency, R5 mapping, R7 masking, R8 flag
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      sleep_sel = TBL[v].slp;
      seg_sel   = TBL[v].seg;
      @(negedge clk);
      press = TBL[v].keys_dn;
      wait_req(2000, 0, '0, 1'b0, lat);
      chk(lat == 801, "R3 latency", 64'(lat), 64'd801);
      chk(keys == TBL[v].want, "R5/R7 key map", 64'(keys), 64'(TBL[v].want));
      chk(sa == TBL[v].want_sa, "R8 sleep flag", 64'(sa), 64'(TBL[v].want_sa));
      release_and_read();
    end
    @(negedge clk);
    sleep_sel = 2'b00; seg_sel = 2'b00;

    // R2 row order inside a window, then R9 chip-select
    @(negedge clk);
    press = 30'h1 << 5;
    wait_req(2000, 0, '0, 1'b1, lat);
    chk(lat == 801, "R3 latency row test", 64'(lat), 64'd801);
    @(negedge clk);
    cs = 1'b1; #1;
    chk(req_n == 1'b1, "R9 cs releases req", 64'(req_n), 64'd1);
    repeat (20) @(posedge clk);
    #1;
    chk(keys == (30'h1 << 5), "R9 keys held", 64'(keys), 64'(30'h1 << 5));
    @(negedge clk);
    cs = 1'b0; #1;
    chk(req_n == 1'b0, "R9 req returns", 64'(req_n), 64'd0);
    release_and_read();

    // R4 pattern changes between the two scans
    @(negedge clk);
    press = 30'h1 << 1;
    wait_req(2000, 400, 30'h1 << 17, 1'b0, lat);
    chk(lat == 1601, "R4 rescan latency", 64'(lat), 64'd1601);
    chk(keys == (30'h1 << 17), "R4 final map", 64'(keys), 64'(30'h1 << 17));

    // R11 reset while pending
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk(req_n == 1'b1 && keys == 30'h0, "R11 reset clears", 64'({req_n, keys}), 64'h40000000);
    @(negedge clk);
    press = '0;
    rst_n = 1'b1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule